// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the clocks of an audio serial port from one fast reference clock. A fractional divider produces the master clock. Its period is an integer number of reference cycles, plus one extra cycle whenever a 16-bit phase accumulator overflows. An integer divider produces the bit clock, and the frame (left/right) clock is derived from the bit clock. Each clock has its own enable and its own ready flag. The ready flag rises once the clock has run for a fixed number of whole periods.

Software programs the divider values through a small register-write port. It sets the master-clock enable and/or the master-mode bit, then polls the ready outputs. Divider values written while a clock is running are applied at the next period boundary, so no shortened pulse is produced. Serial data shifting is not part of this block.

Top module: `aud_clkgen`

## Requirements
- R1: While reset is held and after it is released, with no writes, `mclk_o`, `bclk_o`, `fclk_o`, `mclk_rdy_o` and `bclk_rdy_o` are all 0.
- R2: Register map on `wr_addr`:
  - Address 0 is control: bit 0 is the master-clock enable and bit 1 is the master-mode (bit/frame clock) enable.
  - Address 1 is the frame register: bits 15:8 hold the bit-clock divide value and bits 31:24 hold the sample width. All other bits are ignored.
  - Address 2 is the master divider: bits 15:0 hold the integer part and bits 31:16 hold the fraction.
  - A write to address 3 has no effect.
  - The control bits are independent: setting only bit 1 leaves `mclk_o` low.
- R3: With a fraction of 0, the master-clock period is the integer part N in reference cycles (values below 2 act as 2). The clock is high for the first floor(N/2) cycles of each period.
- R4: The master clock adds the fraction to a 16-bit accumulator at each period end. The accumulator is cleared on enable. The next period is N+1 when that addition carries out and N otherwise, so the first period is always N.
- R5: With divide value D, the bit clock toggles every D+1 reference cycles. Its period is 2(D+1) with 50% duty, and it starts low for D+1 cycles after enable.
- R6: The frame clock changes only on a bit-clock falling edge. It toggles after every W falling edges, where W is the sample width (0 acts as 1). After the n-th falling edge since enable its value is floor(n/W) mod 2.
- R7: `mclk_rdy_o` rises at the start of the 5th master-clock period after enable, which is after 4 complete periods. It drops in the same cycle the enable bit reads 0.
- R8: `bclk_rdy_o` rises with the 4th bit-clock falling edge after master mode is set. It drops in the same cycle the master-mode bit reads 0.
- R9: A divider value written while its clock runs is used only from the next period boundary. The period in progress completes with its old length.
- R10: One reference cycle after master mode is cleared, `bclk_o` and `fclk_o` are 0 and stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| mclk_o | output | 1 | Master clock |
| bclk_o | output | 1 | Bit clock |
| fclk_o | output | 1 | Frame (left/right select) clock |
| mclk_rdy_o | output | 1 | Master clock stable |
| bclk_rdy_o | output | 1 | Bit and frame clocks running |

## Verification
The assertions assume the integer divider is reprogrammed only with values of 2 or more. They also assume each enable is held for at least one reference cycle before its clock is observed, and that register writes arrive synchronously to the reference clock. The stimulus meets these assumptions. It writes every divider value before the matching enable, or during a running period when testing the deferred update. It drives the write port only at falling edges, and it uses integer parts 5, 6 and 9 with bit-clock divide 2 and width 8.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int INT_W    = 16;
  localparam int FRAC_W   = 16;
  localparam int BDIV_W   = 8;
  localparam int WID_W    = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_FRAME = 2'd1;
  localparam logic [ADDR_W-1:0] A_MDIV  = 2'd2;

  localparam int CTRL_MCLK_BIT   = 0;
  localparam int CTRL_MASTER_BIT = 1;
  localparam int FRAME_BDIV_LSB  = 8;
  localparam int FRAME_WID_LSB   = 24;
  localparam int MDIV_INT_LSB    = 0;
  localparam int MDIV_FRAC_LSB   = 16;

  typedef struct packed {
    logic              mclk_en;
    logic              master;
    logic [BDIV_W-1:0] bdiv;
    logic [WID_W-1:0]  width;
    logic [INT_W-1:0]  mint;
    logic [FRAC_W-1:0] mfrac;
  } clk_cfg_t;
endpackage

// File: rtl/aud_clk_regs.sv
module aud_clk_regs
  import aud_clk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output clk_cfg_t          cfg_o
);
  clk_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          cfg_d.mclk_en = wr_data[CTRL_MCLK_BIT];
          cfg_d.master  = wr_data[CTRL_MASTER_BIT];
        end
        A_FRAME: begin
          cfg_d.bdiv  = wr_data[FRAME_BDIV_LSB +: BDIV_W];
          cfg_d.width = wr_data[FRAME_WID_LSB +: WID_W];
        end
        A_MDIV: begin
          cfg_d.mint  = wr_data[MDIV_INT_LSB +: INT_W];
          cfg_d.mfrac = wr_data[MDIV_FRAC_LSB +: FRAC_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)) else $error("cfg changed without write"); // R2
endmodule

// File: rtl/aud_mclk_div.sv
module aud_mclk_div #(
  parameter int INT_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int READY_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              mclk_o,
  output logic              ready_o
);
  localparam int RC_W = $clog2(READY_CNT + 1);
  localparam int P_W  = INT_W + 1;

  logic [P_W-1:0]    cnt_q, cnt_d, per_q, per_d, int_eff;
  logic [FRAC_W-1:0] acc_q, acc_d, sum;
  logic [RC_W-1:0]   rcnt_q, rcnt_d;
  logic              carry, last;

  always_comb begin
    int_eff = (int_i < INT_W'(2)) ? P_W'(2) : {1'b0, int_i};
    {carry, sum} = {1'b0, acc_q} + {1'b0, frac_i};
    last   = (cnt_q == per_q - 1'b1);
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    per_d  = per_q;
    rcnt_d = rcnt_q;
    if (!en) begin
      cnt_d  = '0;
      acc_d  = '0;
      per_d  = int_eff;
      rcnt_d = '0;
    end else if (last) begin
      cnt_d = '0;
      acc_d = sum;
      per_d = int_eff + {{INT_W{1'b0}}, carry};
      if (rcnt_q != RC_W'(READY_CNT)) rcnt_d = rcnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      per_q  <= P_W'(2);
      rcnt_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      per_q  <= per_d;
      rcnt_q <= rcnt_d;
    end
  end

  assign mclk_o  = en & (cnt_q < (per_q >> 1));
  assign ready_o = en & (rcnt_q == RC_W'(READY_CNT));

  AST_MCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt_q < per_q) else $error("count beyond period"); // R3
  AST_MPER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && last |=> (per_q == $past(int_eff)) || (per_q == $past(int_eff) + 1'b1)) else $error("period step"); // R4
  AST_MPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && cnt_q != '0 |-> $stable(per_q)) else $error("period changed mid-cycle"); // R9
  AST_MRDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(en)) else $error("ready without enable"); // R7
endmodule

// File: rtl/aud_bclk_div.sv
module aud_bclk_div #(
  parameter int DIV_W     = 8,
  parameter int WID_W     = 8,
  parameter int READY_CNT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_i,
  input  logic [WID_W-1:0] wid_i,
  output logic             bclk_o,
  output logic             fclk_o,
  output logic             ready_o
);
  localparam int RC_W = $clog2(READY_CNT + 1);

  logic [DIV_W-1:0] bcnt_q, bcnt_d, bdiv_q, bdiv_d;
  logic [WID_W-1:0] fcnt_q, fcnt_d, wid_q, wid_d, wid_eff;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;
  logic             bclk_q, bclk_d, fclk_q, fclk_d, half;

  always_comb begin
    wid_eff = (wid_i == '0) ? WID_W'(1) : wid_i;
    half    = (bcnt_q == bdiv_q);
    bcnt_d  = bcnt_q;
    bdiv_d  = bdiv_q;
    fcnt_d  = fcnt_q;
    wid_d   = wid_q;
    rcnt_d  = rcnt_q;
    bclk_d  = bclk_q;
    fclk_d  = fclk_q;
    if (!en) begin
      bcnt_d = '0;
      bdiv_d = div_i;
      fcnt_d = '0;
      wid_d  = wid_eff;
      rcnt_d = '0;
      bclk_d = 1'b0;
      fclk_d = 1'b0;
    end else if (half) begin
      bcnt_d = '0;
      bclk_d = ~bclk_q;
      if (bclk_q) begin
        bdiv_d = div_i;
        wid_d  = wid_eff;
        if (rcnt_q != RC_W'(READY_CNT)) rcnt_d = rcnt_q + 1'b1;
        if (fcnt_q >= wid_q - 1'b1) begin
          fcnt_d = '0;
          fclk_d = ~fclk_q;
        end else begin
          fcnt_d = fcnt_q + 1'b1;
        end
      end
    end else begin
      bcnt_d = bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      bdiv_q <= '0;
      fcnt_q <= '0;
      wid_q  <= WID_W'(1);
      rcnt_q <= '0;
      bclk_q <= 1'b0;
      fclk_q <= 1'b0;
    end else begin
      bcnt_q <= bcnt_d;
      bdiv_q <= bdiv_d;
      fcnt_q <= fcnt_d;
      wid_q  <= wid_d;
      rcnt_q <= rcnt_d;
      bclk_q <= bclk_d;
      fclk_q <= fclk_d;
    end
  end

  assign bclk_o  = bclk_q;
  assign fclk_o  = fclk_q;
  assign ready_o = en & (rcnt_q == RC_W'(READY_CNT));

  AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en && !half |=> $stable(bclk_q) || !en) else $error("bit clock early edge"); // R5
  AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    en && $past(en) && (fclk_q != $past(fclk_q)) |-> $fell(bclk_q)) else $error("frame edge off fall"); // R6
  AST_BRDY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(en)) else $error("ready without master"); // R8
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en && $past(!en) |-> !bclk_q && !fclk_q) else $error("clock active while off"); // R10
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clk_pkg::*;
#(
  parameter int READY_CNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        mclk_o,
  output logic        bclk_o,
  output logic        fclk_o,
  output logic        mclk_rdy_o,
  output logic        bclk_rdy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  clk_cfg_t   cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  aud_clk_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg)
  );

  aud_mclk_div #(
    .INT_W     (INT_W),
    .FRAC_W    (FRAC_W),
    .READY_CNT (READY_CNT)
  ) i_mclk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (cfg.mclk_en),
    .int_i   (cfg.mint),
    .frac_i  (cfg.mfrac),
    .mclk_o  (mclk_o),
    .ready_o (mclk_rdy_o)
  );

  aud_bclk_div #(
    .DIV_W     (BDIV_W),
    .WID_W     (WID_W),
    .READY_CNT (READY_CNT)
  ) i_bclk (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .en      (cfg.master),
    .div_i   (cfg.bdiv),
    .wid_i   (cfg.width),
    .bclk_o  (bclk_o),
    .fclk_o  (fclk_o),
    .ready_o (bclk_rdy_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> !mclk_o && !bclk_o && !fclk_o) else $error("outputs active at reset exit"); // R1
endmodule

// File: tb/test_aud_clkgen.sv
module test_aud_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        mclk_o, bclk_o, fclk_o, mclk_rdy_o, bclk_rdy_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    mq[$];
  string m_tag = "R3";
  bit    m_arm = 1'b0, m_have = 1'b0, m_prev = 1'b0;
  int    m_cnt = 0, m_hi = 0, m_rises = 0;

  bit    b_arm = 1'b0, b_have = 1'b0, b_prev = 1'b0;
  int    b_cnt = 0, b_hi = 0, b_falls = 0;
  int    b_per_exp = 6, b_wid = 8;

  always #5 clk = ~clk;

  aud_clkgen i_aud_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .mclk_rdy_o(mclk_rdy_o), .bclk_rdy_o(bclk_rdy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // master clock monitor: pops expected periods from the scoreboard queue
  always @(negedge clk) begin
    if (!m_arm) begin
      m_have = 1'b0; m_rises = 0; m_prev = mclk_o;
    end else begin
      if (mclk_o && !m_prev) begin
        if (m_have && mq.size() > 0) begin
          int e;
          e = mq.pop_front();
          chk(m_cnt + 1 == e, {m_tag, " period"}, m_cnt + 1, e);
          chk(m_hi == e / 2, {m_tag, " high time"}, m_hi, e / 2);
        end
        m_have = 1'b1; m_cnt = 0; m_hi = 1; m_rises++;
      end else begin
        m_cnt++;
        if (mclk_o) m_hi++;
      end
      m_prev = mclk_o;
    end
  end

  // bit/frame clock monitor
  always @(negedge clk) begin
    if (!b_arm) begin
      b_have = 1'b0; b_falls = 0; b_prev = bclk_o;
    end else begin
      if (bclk_o && !b_prev) begin
        if (b_have) begin
          chk(b_cnt + 1 == b_per_exp, "R5 bclk period", b_cnt + 1, b_per_exp);
          chk(b_hi == b_per_exp / 2, "R5 bclk high", b_hi, b_per_exp / 2);
        end
        b_have = 1'b1; b_cnt = 0; b_hi = 1;
      end else begin
        b_cnt++;
        if (bclk_o) b_hi++;
      end
      if (!bclk_o && b_prev) begin
        b_falls++;
        chk(int'(fclk_o) == (b_falls / b_wid) % 2, "R6 frame value", int'(fclk_o), (b_falls / b_wid) % 2);
        chk(mclk_o == 1'b0, "R2 master bit alone keeps mclk low", int'(mclk_o), 0);
      end
      b_prev = bclk_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({mclk_o, bclk_o, fclk_o, mclk_rdy_o, bclk_rdy_o} == 5'b0, "R1 in reset", int'({mclk_o, bclk_o, fclk_o, mclk_rdy_o, bclk_rdy_o}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({mclk_o, bclk_o, fclk_o, mclk_rdy_o, bclk_rdy_o} == 5'b0, "R1 after reset", int'({mclk_o, bclk_o, fclk_o, mclk_rdy_o, bclk_rdy_o}), 0);

    // R3 / R7: integer period 6, ready after 4 periods
    wr(2'd2, 32'h0000_0006);
    m_tag = "R3";
    for (int i = 0; i < 6; i++) mq.push_back(6);
    m_arm = 1'b1;
    wr(2'd0, 32'h1);
    do begin @(negedge clk); #1; end while (m_rises < 4);
    chk(mclk_rdy_o == 1'b0, "R7 ready low at 4th rise", int'(mclk_rdy_o), 0);
    do begin @(negedge clk); #1; end while (m_rises < 5);
    chk(mclk_rdy_o == 1'b1, "R7 ready high at 5th rise", int'(mclk_rdy_o), 1);
    wait (mq.size() == 0);
    wr(2'd3, 32'hFFFF_FFFF);
    m_tag = "R2";
    for (int i = 0; i < 4; i++) mq.push_back(6);
    wait (mq.size() == 0);
    wr(2'd0, 32'h0);
    #1;
    chk(mclk_rdy_o == 1'b0, "R7 ready clears with enable", int'(mclk_rdy_o), 0);
    chk(mclk_o == 1'b0, "R7 mclk low when disabled", int'(mclk_o), 0);
    m_arm = 1'b0;

    // R4: fractional sequence int 5, fraction 0x4000
    begin
      int acc;
      acc = 0;
      mq.delete();
      mq.push_back(5);
      for (int k = 0; k < 12; k++) begin
        acc = acc + 32'h4000;
        mq.push_back(acc >= 65536 ? 6 : 5);
        acc = acc % 65536;
      end
    end
    wr(2'd2, {16'h4000, 16'd5});
    m_tag = "R4";
    m_arm = 1'b1;
    wr(2'd0, 32'h1);
    wait (mq.size() == 0);
    wr(2'd0, 32'h0);
    m_arm = 1'b0;

    // R9: change integer part during the first period
    mq.delete();
    wr(2'd2, 32'h0000_0006);
    m_tag = "R9";
    mq.push_back(6); mq.push_back(9); mq.push_back(9); mq.push_back(9);
    m_arm = 1'b1;
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h0000_0009);
    wait (mq.size() == 0);
    wr(2'd0, 32'h0);
    m_arm = 1'b0;

    // R5 / R6 / R8 / R10: bit clock divide 2, width 8, master bit only
    wr(2'd1, {8'd8, 8'h00, 8'd2, 8'hFF});
    b_per_exp = 6; b_wid = 8;
    b_arm = 1'b1;
    wr(2'd0, 32'h2);
    do begin @(negedge clk); #1; end while (b_falls < 3);
    chk(bclk_rdy_o == 1'b0, "R8 ready low at 3rd fall", int'(bclk_rdy_o), 0);
    do begin @(negedge clk); #1; end while (b_falls < 4);
    chk(bclk_rdy_o == 1'b1, "R8 ready high at 4th fall", int'(bclk_rdy_o), 1);
    do begin @(negedge clk); #1; end while (b_falls < 40);
    wr(2'd0, 32'h0);
    #1;
    chk(bclk_rdy_o == 1'b0, "R8 ready clears with master bit", int'(bclk_rdy_o), 0);
    b_arm = 1'b0;
    @(negedge clk); #1;
    chk(bclk_o == 1'b0, "R10 bclk low after stop", int'(bclk_o), 0);
    chk(fclk_o == 1'b0, "R10 fclk low after stop", int'(fclk_o), 0);
    repeat (20) @(negedge clk);
    chk({bclk_o, fclk_o} == 2'b00, "R10 clocks stay low", int'({bclk_o, fclk_o}), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule